// File: doc/BRIEF.md
# Multi-queue descriptor fetch scheduler

This block chooses which of several DMA descriptor rings is allowed to fetch next, and how many descriptors that fetch may carry. Each ring has its own context: producer index, fetch pointer (the engine-side consumer index), ring base address, a direction bit, a credit-throttle enable and a credit counter. Software moves the producer index through a doorbell port. Every doorbell is echoed, as a queue number and an index increment, on a status port that an external traffic manager can use for prioritisation.

In each cycle where the request register is free, a round-robin search picks an eligible ring and loads one memory-read request. A request carries the queue number, a byte address, a descriptor count and the direction. The count is the smallest of several limits: descriptors pending, descriptors per maximum read request, room left before the end of the ring, free space reported for that direction's descriptor buffer, and, for throttled rings, the credit held. A ring stays busy from its grant until the read is reported complete, so it never has two reads in flight. Completion data, reordering and the host bus are handled elsewhere.

Top module: `dfs_fetch_sched`

## Requirements
- R1: Eligible queues are granted in round-robin order. The search starts at the queue after the one granted most recently, and after reset queue 0 is searched first.
- R2: A queue is never granted again until a completion (`rd_done_valid_i` with its number) has arrived for its previous request.
- R3: The descriptor count of every request is between 1 and MRRS_BYTES/DESC_BYTES (16 with defaults).
- R4: The count never exceeds the free-space input of the queue's direction: `buf_free_c2h_i` when the direction bit is 1 (card-to-host), `buf_free_h2c_i` when it is 0. Zero free space blocks that direction.
- R5: For a throttled queue, the count never exceeds its credit, and the credit drops by the count at grant. A throttled queue with zero credit is never granted.
- R6: A credit return adds `crd_cnt_i` to the queue's credit. A return that lands in the same cycle as that queue's grant deduction is also kept.
- R7: One cycle after a doorbell, `tm_valid_o` is high with the doorbell's queue and `tm_inc_o` = (new producer index − old producer index) mod RING_DEPTH. Otherwise `tm_valid_o` is low.
- R8: The request address is base + fetch_pointer × DESC_BYTES. The count is also capped at RING_DEPTH − fetch_pointer, so a request never wraps. The fetch pointer then advances by the count, modulo RING_DEPTH.
- R9: Pending descriptors are (producer index − fetch pointer) mod RING_DEPTH. A queue with none pending is never granted.
- R10: A context write sets the queue's base, direction and throttle enable, and clears its producer index, fetch pointer and credit.
- R11: After reset `rd_req_valid_o` is low. A request appears the cycle after its grant and holds all its fields while `rd_req_ready_i` is low. A new grant may load in the cycle the previous request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_we_i | input | 1 | Context write strobe |
| ctx_qid_i | input | QW | Queue being configured |
| ctx_base_i | input | ADDR_W | Ring base address |
| ctx_c2h_i | input | 1 | Direction: 1 card-to-host, 0 host-to-card |
| ctx_thr_en_i | input | 1 | Credit throttle enable |
| db_valid_i | input | 1 | Producer-index doorbell strobe |
| db_qid_i | input | QW | Doorbell queue |
| db_pidx_i | input | IW | New producer index |
| crd_valid_i | input | 1 | Credit return strobe |
| crd_qid_i | input | QW | Credit return queue |
| crd_cnt_i | input | CRD_W | Returned descriptors |
| buf_free_h2c_i | input | BW | Free host-to-card descriptor buffer slots |
| buf_free_c2h_i | input | BW | Free card-to-host descriptor buffer slots |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_qid_o | output | QW | Requesting queue |
| rd_req_addr_o | output | ADDR_W | Byte address of first descriptor |
| rd_req_cnt_o | output | CW | Descriptor count |
| rd_req_c2h_o | output | 1 | Direction of the request |
| rd_done_valid_i | input | 1 | Read completion strobe |
| rd_done_qid_i | input | QW | Completed queue |
| tm_valid_o | output | 1 | Traffic-manager status valid |
| tm_qid_o | output | QW | Queue of the doorbell |
| tm_inc_o | output | IW | Producer index increment |

## Verification
The hardest collision is a credit return for a throttled queue that lands on the same clock edge as that queue's grant. In that case the deduction and the addition both hit the credit register at once. The bench sets it up by making one throttled queue the only eligible one: it rings its doorbell, then sends the credit return in the very next cycle, which is the grant cycle. It judges the result by the size of the following fetch, which must equal the returned amount. A second pairing, acceptance of one request in the same cycle another queue is granted, is checked cycle by cycle against a reference model of the whole context set.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic {DIR_H2C = 1'b0, DIR_C2H = 1'b1} dir_e;

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dfs_fetch_calc.sv
module dfs_fetch_calc import dfs_pkg::*; #(
  parameter int RING_DEPTH = 64,
  parameter int MAX_RD     = 16,
  parameter int BUF_DEPTH  = 64,
  parameter int CRD_W      = 16,
  localparam int IW = $clog2(RING_DEPTH),
  localparam int CW = $clog2(MAX_RD + 1),
  localparam int BW = $clog2(BUF_DEPTH + 1)
) (
  input  logic [IW-1:0]    pidx_i,
  input  logic [IW-1:0]    fptr_i,
  input  logic             busy_i,
  input  logic             thr_en_i,
  input  logic [CRD_W-1:0] credit_i,
  input  logic [BW-1:0]    buf_free_i,
  output logic [CW-1:0]    cnt_o,
  output logic             elig_o
);
  int unsigned avail, to_end, lim;

  always_comb begin
    avail  = 32'(IW'(pidx_i - fptr_i));
    to_end = RING_DEPTH - 32'(fptr_i);
    lim    = umin(avail, MAX_RD);
    lim    = umin(lim, to_end);
    lim    = umin(lim, 32'(buf_free_i));
    if (thr_en_i) lim = umin(lim, 32'(credit_i));
    cnt_o  = CW'(lim);
    elig_o = !busy_i && (lim != 0);
  end
endmodule

// File: rtl/dfs_rr_arb.sv
module dfs_rr_arb #(
  parameter int N = 8,
  localparam int QW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [QW-1:0] last_i,
  output logic          any_o,
  output logic [QW-1:0] idx_o
);
  int k;

  // search starts one past the last winner, wrapping
  always_comb begin
    any_o = 1'b0;
    idx_o = last_i;
    k     = 0;
    for (int i = 1; i <= N; i++) begin
      k = (int'(last_i) + i) % N;
      if (!any_o && req_i[k]) begin
        any_o = 1'b1;
        idx_o = QW'(k);
      end
    end
  end
endmodule

// File: rtl/dfs_tm_status.sv
module dfs_tm_status #(
  parameter int NUM_Q      = 8,
  parameter int RING_DEPTH = 64,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IW = $clog2(RING_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          db_valid_i,
  input  logic [QW-1:0] db_qid_i,
  input  logic [IW-1:0] db_pidx_i,
  input  logic [IW-1:0] old_pidx_i,
  output logic          tm_valid_o,
  output logic [QW-1:0] tm_qid_o,
  output logic [IW-1:0] tm_inc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_valid_o <= 1'b0;
      tm_qid_o   <= '0;
      tm_inc_o   <= '0;
    end else begin
      tm_valid_o <= db_valid_i;
      if (db_valid_i) begin
        tm_qid_o <= db_qid_i;
        tm_inc_o <= db_pidx_i - old_pidx_i;
      end
    end
  end

  AST_TM_FOLLOWS_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_i |=> tm_valid_o) else $error("tm status missing"); // R7
  AST_TM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_valid_i |=> !tm_valid_o) else $error("spurious tm status"); // R7
endmodule

// File: rtl/dfs_fetch_sched.sv
module dfs_fetch_sched import dfs_pkg::*; #(
  parameter int NUM_Q      = 8,
  parameter int RING_DEPTH = 64,
  parameter int DESC_BYTES = 32,
  parameter int MRRS_BYTES = 512,
  parameter int BUF_DEPTH  = 64,
  parameter int ADDR_W     = 64,
  parameter int CRD_W      = 16,
  localparam int QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IW     = $clog2(RING_DEPTH),
  localparam int MAX_RD = MRRS_BYTES / DESC_BYTES,
  localparam int CW     = $clog2(MAX_RD + 1),
  localparam int BW     = $clog2(BUF_DEPTH + 1),
  localparam int DSH    = $clog2(DESC_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctx_we_i,
  input  logic [QW-1:0]     ctx_qid_i,
  input  logic [ADDR_W-1:0] ctx_base_i,
  input  logic              ctx_c2h_i,
  input  logic              ctx_thr_en_i,
  input  logic              db_valid_i,
  input  logic [QW-1:0]     db_qid_i,
  input  logic [IW-1:0]     db_pidx_i,
  input  logic              crd_valid_i,
  input  logic [QW-1:0]     crd_qid_i,
  input  logic [CRD_W-1:0]  crd_cnt_i,
  input  logic [BW-1:0]     buf_free_h2c_i,
  input  logic [BW-1:0]     buf_free_c2h_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [QW-1:0]     rd_req_qid_o,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  output logic [CW-1:0]     rd_req_cnt_o,
  output logic              rd_req_c2h_o,
  input  logic              rd_done_valid_i,
  input  logic [QW-1:0]     rd_done_qid_i,
  output logic              tm_valid_o,
  output logic [QW-1:0]     tm_qid_o,
  output logic [IW-1:0]     tm_inc_o
);
  logic [IW-1:0]     pidx_q [NUM_Q];
  logic [IW-1:0]     fptr_q [NUM_Q];
  logic [ADDR_W-1:0] base_q [NUM_Q];
  logic [CRD_W-1:0]  cred_q [NUM_Q];
  logic [CRD_W-1:0]  cred_nxt [NUM_Q];
  dir_e              dir_q  [NUM_Q];
  logic [NUM_Q-1:0]  thr_q;
  logic [NUM_Q-1:0]  busy_q;
  logic [QW-1:0]     last_q;

  logic [CW-1:0]     cnt_w [NUM_Q];
  logic [NUM_Q-1:0]  elig_w;
  logic              arb_any;
  logic [QW-1:0]     gnt_idx;
  logic [CW-1:0]     gnt_cnt;
  logic              can_issue, do_grant;

  // per-queue fetch size limiter
  for (genvar g = 0; g < NUM_Q; g++) begin : g_calc
    logic [BW-1:0] free_w;
    assign free_w = (dir_q[g] == DIR_C2H) ? buf_free_c2h_i : buf_free_h2c_i;

    dfs_fetch_calc #(
      .RING_DEPTH(RING_DEPTH), .MAX_RD(MAX_RD),
      .BUF_DEPTH(BUF_DEPTH),   .CRD_W(CRD_W)
    ) u_calc (
      .pidx_i    (pidx_q[g]),
      .fptr_i    (fptr_q[g]),
      .busy_i    (busy_q[g]),
      .thr_en_i  (thr_q[g]),
      .credit_i  (cred_q[g]),
      .buf_free_i(free_w),
      .cnt_o     (cnt_w[g]),
      .elig_o    (elig_w[g])
    );
  end

  dfs_rr_arb #(.N(NUM_Q)) u_arb (
    .req_i (elig_w),
    .last_i(last_q),
    .any_o (arb_any),
    .idx_o (gnt_idx)
  );

  assign can_issue = !rd_req_valid_o || rd_req_ready_i;
  assign do_grant  = can_issue && arb_any;
  assign gnt_cnt   = cnt_w[gnt_idx];

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      cred_nxt[q] = cred_q[q];
      if (do_grant && gnt_idx == QW'(q) && thr_q[q])
        cred_nxt[q] = cred_nxt[q] - CRD_W'(gnt_cnt);
      if (crd_valid_i && crd_qid_i == QW'(q))
        cred_nxt[q] = cred_nxt[q] + crd_cnt_i;
    end
  end

  // queue contexts; a context write takes priority over same-cycle updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < NUM_Q; q++) begin
        pidx_q[q] <= '0;
        fptr_q[q] <= '0;
        base_q[q] <= '0;
        cred_q[q] <= '0;
        dir_q[q]  <= DIR_H2C;
      end
      thr_q  <= '0;
      busy_q <= '0;
      last_q <= QW'(NUM_Q - 1);
    end else begin
      if (do_grant) last_q <= gnt_idx;
      for (int q = 0; q < NUM_Q; q++) begin
        if (ctx_we_i && ctx_qid_i == QW'(q)) begin
          base_q[q] <= ctx_base_i;
          dir_q[q]  <= ctx_c2h_i ? DIR_C2H : DIR_H2C;
          thr_q[q]  <= ctx_thr_en_i;
          pidx_q[q] <= '0;
          fptr_q[q] <= '0;
          cred_q[q] <= '0;
        end else begin
          if (db_valid_i && db_qid_i == QW'(q)) pidx_q[q] <= db_pidx_i;
          if (do_grant && gnt_idx == QW'(q)) fptr_q[q] <= fptr_q[q] + IW'(gnt_cnt);
          cred_q[q] <= cred_nxt[q];
        end
        if (do_grant && gnt_idx == QW'(q))                busy_q[q] <= 1'b1;
        else if (rd_done_valid_i && rd_done_qid_i == QW'(q)) busy_q[q] <= 1'b0;
      end
    end
  end

  // request register, loaded at grant, held until accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_valid_o <= 1'b0;
      rd_req_qid_o   <= '0;
      rd_req_addr_o  <= '0;
      rd_req_cnt_o   <= '0;
      rd_req_c2h_o   <= 1'b0;
    end else if (do_grant) begin
      rd_req_valid_o <= 1'b1;
      rd_req_qid_o   <= gnt_idx;
      rd_req_addr_o  <= base_q[gnt_idx] + (ADDR_W'(fptr_q[gnt_idx]) << DSH);
      rd_req_cnt_o   <= gnt_cnt;
      rd_req_c2h_o   <= (dir_q[gnt_idx] == DIR_C2H);
    end else if (rd_req_ready_i) begin
      rd_req_valid_o <= 1'b0;
    end
  end

  dfs_tm_status #(.NUM_Q(NUM_Q), .RING_DEPTH(RING_DEPTH)) u_tm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .db_valid_i(db_valid_i),
    .db_qid_i  (db_qid_i),
    .db_pidx_i (db_pidx_i),
    .old_pidx_i(pidx_q[db_qid_i]),
    .tm_valid_o(tm_valid_o),
    .tm_qid_o  (tm_qid_o),
    .tm_inc_o  (tm_inc_o)
  );

  AST_RR_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_grant |-> elig_w[gnt_idx]) else $error("grant to ineligible queue"); // R1
  AST_ONE_INFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_grant |-> !busy_q[gnt_idx]) else $error("second read in flight"); // R2
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o |-> busy_q[rd_req_qid_o]) else $error("request for idle queue"); // R2
  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o |-> (rd_req_cnt_o != '0) && (32'(rd_req_cnt_o) <= MAX_RD))
    else $error("count out of range"); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_qid_o)
      && $stable(rd_req_addr_o) && $stable(rd_req_cnt_o))
    else $error("request changed while stalled"); // R11
endmodule

// File: tb/dfs_fetch_sched_tb.sv
module dfs_fetch_sched_tb;
  localparam int NQ = 8, RD = 64, DB = 32, MR = 512, BUFD = 64, AW = 64, CRW = 16;
  localparam int QW = 3, IW = 6, CW = 5, BW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni;
  logic          ctx_we_i, ctx_c2h_i, ctx_thr_en_i;
  logic [QW-1:0] ctx_qid_i;
  logic [AW-1:0] ctx_base_i;
  logic          db_valid_i;
  logic [QW-1:0] db_qid_i;
  logic [IW-1:0] db_pidx_i;
  logic          crd_valid_i;
  logic [QW-1:0] crd_qid_i;
  logic [CRW-1:0] crd_cnt_i;
  logic [BW-1:0] buf_free_h2c_i, buf_free_c2h_i;
  logic          rd_req_valid_o, rd_req_ready_i, rd_req_c2h_o;
  logic [QW-1:0] rd_req_qid_o;
  logic [AW-1:0] rd_req_addr_o;
  logic [CW-1:0] rd_req_cnt_o;
  logic          rd_done_valid_i;
  logic [QW-1:0] rd_done_qid_i;
  logic          tm_valid_o;
  logic [QW-1:0] tm_qid_o;
  logic [IW-1:0] tm_inc_o;

  dfs_fetch_sched #(.NUM_Q(NQ), .RING_DEPTH(RD), .DESC_BYTES(DB), .MRRS_BYTES(MR),
                    .BUF_DEPTH(BUFD), .ADDR_W(AW), .CRD_W(CRW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctx_we_i(ctx_we_i), .ctx_qid_i(ctx_qid_i), .ctx_base_i(ctx_base_i),
    .ctx_c2h_i(ctx_c2h_i), .ctx_thr_en_i(ctx_thr_en_i),
    .db_valid_i(db_valid_i), .db_qid_i(db_qid_i), .db_pidx_i(db_pidx_i),
    .crd_valid_i(crd_valid_i), .crd_qid_i(crd_qid_i), .crd_cnt_i(crd_cnt_i),
    .buf_free_h2c_i(buf_free_h2c_i), .buf_free_c2h_i(buf_free_c2h_i),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_qid_o(rd_req_qid_o), .rd_req_addr_o(rd_req_addr_o),
    .rd_req_cnt_o(rd_req_cnt_o), .rd_req_c2h_o(rd_req_c2h_o),
    .rd_done_valid_i(rd_done_valid_i), .rd_done_qid_i(rd_done_qid_i),
    .tm_valid_o(tm_valid_o), .tm_qid_o(tm_qid_o), .tm_inc_o(tm_inc_o)
  );

  typedef struct { int q; logic [63:0] addr; int cnt; bit c2h; } req_t;

  // reference model state
  int          m_pidx [NQ], m_fptr [NQ], m_cred [NQ];
  logic [63:0] m_base [NQ];
  bit          m_c2h [NQ], m_thr [NQ], m_busy [NQ], obs_busy [NQ];
  int          m_last, m_out_q;
  bit          m_valid, m_new, m_tm_pend;

  req_t exp_req [$];
  int   exp_tm_q [$], exp_tm_inc [$];
  int   done_q [$], done_due [$];
  int   log_q [$], log_cnt [$];
  bit   log_c2h [$];
  logic [63:0] log_addr [$];

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int calc(input int q);
    int c, b;
    c = (m_pidx[q] - m_fptr[q]) & (RD - 1);
    if (c > MR / DB) c = MR / DB;
    if (c > RD - m_fptr[q]) c = RD - m_fptr[q];
    b = m_c2h[q] ? int'(buf_free_c2h_i) : int'(buf_free_h2c_i);
    if (c > b) c = b;
    if (m_thr[q] && c > m_cred[q]) c = m_cred[q];
    return c;
  endfunction

  // driver side: advance the model over the coming edge, push expected items
  task automatic model_adv();
    int cnt [NQ];
    int g;
    bit acc, can;
    g = -1;
    for (int q = 0; q < NQ; q++) cnt[q] = calc(q);
    acc = m_valid && rd_req_ready_i;
    can = !m_valid || rd_req_ready_i;
    if (can)
      for (int i = 1; i <= NQ; i++) begin
        int k;
        k = (m_last + i) % NQ;
        if (g < 0 && cnt[k] > 0 && !m_busy[k]) g = k;
      end
    if (acc) begin
      done_q.push_back(m_out_q);
      done_due.push_back(cyc + 2 + (m_out_q % 3));
    end
    if (rd_done_valid_i) m_busy[rd_done_qid_i] = 1'b0;
    m_new = 1'b0;
    if (g >= 0) begin
      req_t r;
      r.q = g; r.addr = m_base[g] + 64'(m_fptr[g] * DB); r.cnt = cnt[g]; r.c2h = m_c2h[g];
      exp_req.push_back(r);
      m_new = 1'b1; m_valid = 1'b1; m_out_q = g; m_last = g; m_busy[g] = 1'b1;
      m_fptr[g] = (m_fptr[g] + cnt[g]) % RD;
      if (m_thr[g]) m_cred[g] = (m_cred[g] - cnt[g]) & 16'hFFFF;
    end else if (acc) m_valid = 1'b0;
    if (crd_valid_i) m_cred[crd_qid_i] = (m_cred[crd_qid_i] + int'(crd_cnt_i)) & 16'hFFFF;
    m_tm_pend = db_valid_i;
    if (db_valid_i) begin
      exp_tm_q.push_back(int'(db_qid_i));
      exp_tm_inc.push_back((int'(db_pidx_i) - m_pidx[db_qid_i]) & (RD - 1));
      m_pidx[db_qid_i] = int'(db_pidx_i);
    end
    if (ctx_we_i) begin
      m_base[ctx_qid_i] = ctx_base_i; m_c2h[ctx_qid_i] = ctx_c2h_i; m_thr[ctx_qid_i] = ctx_thr_en_i;
      m_pidx[ctx_qid_i] = 0; m_fptr[ctx_qid_i] = 0; m_cred[ctx_qid_i] = 0;
    end
  endtask

  // monitor side: pop and compare what the design produced
  task automatic monitor();
    chk(rd_req_valid_o == m_valid, "R11 request valid", 64'(rd_req_valid_o), 64'(m_valid));
    if (m_new && exp_req.size() > 0) begin
      req_t r;
      r = exp_req.pop_front();
      chk(int'(rd_req_qid_o) == r.q, "R1 granted queue", 64'(rd_req_qid_o), 64'(r.q));
      chk(rd_req_addr_o == r.addr, "R8 request address", rd_req_addr_o, r.addr);
      chk(int'(rd_req_cnt_o) == r.cnt, "R3 descriptor count", 64'(rd_req_cnt_o), 64'(r.cnt));
      chk(rd_req_c2h_o == r.c2h, "R10 request direction", 64'(rd_req_c2h_o), 64'(r.c2h));
      chk(!obs_busy[rd_req_qid_o], "R2 grant while in flight", 64'(rd_req_qid_o), 64'hFF);
      obs_busy[rd_req_qid_o] = 1'b1;
      log_q.push_back(int'(rd_req_qid_o)); log_cnt.push_back(int'(rd_req_cnt_o));
      log_addr.push_back(rd_req_addr_o); log_c2h.push_back(rd_req_c2h_o);
    end
    chk(tm_valid_o == m_tm_pend, "R7 status valid", 64'(tm_valid_o), 64'(m_tm_pend));
    if (tm_valid_o && m_tm_pend && exp_tm_q.size() > 0) begin
      int eq, ei;
      eq = exp_tm_q.pop_front(); ei = exp_tm_inc.pop_front();
      chk(int'(tm_qid_o) == eq, "R7 status queue", 64'(tm_qid_o), 64'(eq));
      chk(int'(tm_inc_o) == ei, "R7 status increment", 64'(tm_inc_o), 64'(ei));
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic step();
    if (done_q.size() > 0 && done_due[0] <= cyc) begin
      rd_done_valid_i = 1'b1;
      rd_done_qid_i   = QW'(done_q[0]);
      obs_busy[done_q[0]] = 1'b0;
      void'(done_q.pop_front()); void'(done_due.pop_front());
    end
    model_adv();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    monitor();
    ctx_we_i = 1'b0; db_valid_i = 1'b0; crd_valid_i = 1'b0; rd_done_valid_i = 1'b0;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      summary_and_end();
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(input int q, input logic [63:0] base, input bit c2h, input bit thr);
    ctx_we_i = 1'b1; ctx_qid_i = QW'(q); ctx_base_i = base; ctx_c2h_i = c2h; ctx_thr_en_i = thr;
    step();
  endtask

  task automatic ring(input int q, input int pidx);
    db_valid_i = 1'b1; db_qid_i = QW'(q); db_pidx_i = IW'(pidx);
    step();
  endtask

  task automatic give(input int q, input int n);
    crd_valid_i = 1'b1; crd_qid_i = QW'(q); crd_cnt_i = CRW'(n);
    step();
  endtask

  function automatic int nth_of(input int q, input int n, input int from);
    int seen;
    seen = 0;
    for (int i = from; i < log_q.size(); i++)
      if (log_q[i] == q) begin
        if (seen == n) return i;
        seen++;
      end
    return -1;
  endfunction

  function automatic int count_of(input int q, input int from);
    int c;
    c = 0;
    for (int i = from; i < log_q.size(); i++) if (log_q[i] == q) c++;
    return c;
  endfunction

  task automatic expect_entry(input int idx, input int q, input int cnt, input logic [63:0] addr, input string tag);
    if (idx < 0 || idx >= log_q.size()) begin
      chk(1'b0, tag, 64'hFFFF, 64'(q));
    end else begin
      chk(log_q[idx] == q, tag, 64'(log_q[idx]), 64'(q));
      chk(log_cnt[idx] == cnt, tag, 64'(log_cnt[idx]), 64'(cnt));
      if (addr != '1) chk(log_addr[idx] == addr, tag, log_addr[idx], addr);
    end
  endtask

  function automatic logic [63:0] qbase(input int q);
    return 64'h1_0000_0000 + (64'(q) << 16);
  endfunction

  initial begin
    int mark, lastq, first;
    rst_ni = 1'b0;
    ctx_we_i = 0; ctx_qid_i = 0; ctx_base_i = 0; ctx_c2h_i = 0; ctx_thr_en_i = 0;
    db_valid_i = 0; db_qid_i = 0; db_pidx_i = 0;
    crd_valid_i = 0; crd_qid_i = 0; crd_cnt_i = 0;
    buf_free_h2c_i = 7'd64; buf_free_c2h_i = 7'd64;
    rd_req_ready_i = 1'b1; rd_done_valid_i = 0; rd_done_qid_i = 0;
    for (int q = 0; q < NQ; q++) begin
      m_pidx[q] = 0; m_fptr[q] = 0; m_cred[q] = 0; m_base[q] = 0;
      m_c2h[q] = 0; m_thr[q] = 0; m_busy[q] = 0; obs_busy[q] = 0;
    end
    m_last = NQ - 1; m_out_q = 0; m_valid = 0; m_new = 0; m_tm_pend = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rd_req_valid_o == 1'b0, "R11 reset request valid", 64'(rd_req_valid_o), 64'h0);
    chk(tm_valid_o == 1'b0, "R7 reset status valid", 64'(tm_valid_o), 64'h0);
    rst_ni = 1'b1;
    idle(2);

    // R10 contexts: odd queues card-to-host, queues 2 and 3 throttled
    for (int q = 0; q < NQ; q++) cfg(q, qbase(q), q[0], (q == 2 || q == 3));

    // R3 / R8 / R9: max-size splits, ring-end cut, empty doorbell
    ring(0, 40);
    idle(40);
    expect_entry(nth_of(0, 0, 0), 0, 16, qbase(0), "R3 first q0 fetch");
    expect_entry(nth_of(0, 1, 0), 0, 16, qbase(0) + 512, "R8 second q0 fetch");
    expect_entry(nth_of(0, 2, 0), 0, 8, qbase(0) + 1024, "R9 q0 remainder");
    ring(0, 10);
    ring(7, 0);
    idle(40);
    expect_entry(nth_of(0, 3, 0), 0, 16, qbase(0) + 1280, "R8 q0 after wrap doorbell");
    expect_entry(nth_of(0, 4, 0), 0, 8, qbase(0) + 1792, "R8 cut at ring end");
    expect_entry(nth_of(0, 5, 0), 0, 10, qbase(0), "R8 restart at ring base");
    chk(count_of(7, 0) == 0, "R9 no fetch with nothing pending", 64'(count_of(7, 0)), 64'h0);

    // R4 / R1: buffers closed, then round-robin release with h2c room 2
    buf_free_h2c_i = 7'd0; buf_free_c2h_i = 7'd0;
    mark = log_q.size();
    ring(1, 3); ring(4, 3); ring(5, 3); ring(6, 3);
    idle(3);
    chk(log_q.size() == mark, "R4 no fetch without buffer room", 64'(log_q.size()), 64'(mark));
    buf_free_h2c_i = 7'd2; buf_free_c2h_i = 7'd64;
    idle(30);
    expect_entry(mark,     1, 3, '1, "R1 order slot 0");
    expect_entry(mark + 1, 4, 2, '1, "R4 h2c capped slot 1");
    expect_entry(mark + 2, 5, 3, '1, "R1 order slot 2");
    expect_entry(mark + 3, 6, 2, '1, "R4 h2c capped slot 3");

    // R1 resume after last granted
    buf_free_h2c_i = 7'd0; buf_free_c2h_i = 7'd0;
    ring(1, 6); ring(5, 6);
    idle(3);
    lastq = log_q[log_q.size() - 1];
    first = (((1 - lastq + NQ) % NQ) < ((5 - lastq + NQ) % NQ)) ? 1 : 5;
    mark = log_q.size();
    buf_free_h2c_i = 7'd64; buf_free_c2h_i = 7'd64;
    idle(20);
    expect_entry(mark, first, 3, '1, "R1 resumes after last winner");

    // R5: throttled queue with zero credit, then limited by credit
    mark = log_q.size();
    ring(2, 10);
    idle(6);
    chk(count_of(2, mark) == 0, "R5 zero credit blocks", 64'(count_of(2, mark)), 64'h0);
    give(2, 4);
    idle(10);
    expect_entry(nth_of(2, 0, mark), 2, 4, qbase(2), "R5 count capped by credit");
    chk(count_of(2, mark) == 1, "R5 credit consumed", 64'(count_of(2, mark)), 64'h1);
    mark = log_q.size();
    give(2, 10);
    idle(10);
    expect_entry(nth_of(2, 0, mark), 2, 6, qbase(2) + 128, "R6 returned credit used");

    // R6: credit return in the grant cycle of the same queue
    give(3, 3);
    idle(2);
    mark = log_q.size();
    ring(3, 20);
    give(3, 5);
    idle(12);
    expect_entry(nth_of(3, 0, mark), 3, 3, qbase(3), "R6 grant on old credit");
    expect_entry(nth_of(3, 1, mark), 3, 5, qbase(3) + 96, "R6 same-cycle return kept");

    // R11: stall while a request is held
    rd_req_ready_i = 1'b0;
    ring(5, 13);
    idle(4);
    chk(rd_req_valid_o == 1'b1, "R11 held valid", 64'(rd_req_valid_o), 64'h1);
    chk(rd_req_qid_o == 3'd5, "R11 held queue", 64'(rd_req_qid_o), 64'h5);
    chk(rd_req_cnt_o == 5'd7, "R11 held count", 64'(rd_req_cnt_o), 64'h7);
    rd_req_ready_i = 1'b1;
    idle(12);

    // R10: reconfigure queue 5 to host-to-card with a new base
    cfg(5, 64'h0000_00AB_CDE0_0000, 1'b0, 1'b0);
    mark = log_q.size();
    ring(5, 2);
    idle(8);
    expect_entry(nth_of(5, 0, mark), 5, 2, 64'h0000_00AB_CDE0_0000, "R10 new base after rewrite");
    if (nth_of(5, 0, mark) >= 0)
      chk(log_c2h[nth_of(5, 0, mark)] == 1'b0, "R10 new direction",
          64'(log_c2h[nth_of(5, 0, mark)]), 64'h0);

    idle(20);
    chk(exp_req.size() == 0, "R11 all expected requests seen", 64'(exp_req.size()), 64'h0);
    chk(exp_tm_q.size() == 0, "R7 all status reports seen", 64'(exp_tm_q.size()), 64'h0);
    summary_and_end();
  end
endmodule